// File: doc/BRIEF.md
# Open-Row Buffer Access Controller

This block sits between a word-wide request port and a row-organised storage bank. It keeps one whole row in a buffer register next to the bank. Each request is sorted into one of three classes: a hit (the addressed row is already in the buffer), a miss (no row is held), or a conflict (a different row is held). The block then runs the matching sequence. Hits are served from the buffer alone. Misses open the row into the buffer. Conflicts first return a modified buffer to the bank and then open the new row.

Writes are never sent straight to the bank. The addressed word is edited inside the buffer and the row is marked as modified. The bank sees the edit only when that row is later pushed out by a conflict. Only one request is in flight at a time. The request port stalls by holding ready low until a multi-cycle sequence finishes.

The bank port is a plain row port with one clock of read latency. A read strobe with a row index returns the whole row on `bank_rdata` during the following cycle. A write strobe stores `bank_wdata` into the indexed row at the clock edge.

Top module: `rowbuf_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `req_ready` is 1, `rsp_valid` is 0, both bank strobes are 0, and no row is held, so the first request is a miss.
- R2: A request address splits into a row index in its upper ROW_AW bits and a column in its lower bits. Column c of a row occupies bits [c*WORD_W +: WORD_W] of the row bus.
- R3: A read with no row held raises `bank_rd` with the request's row in the cycle after acceptance. The response comes two cycles after that strobe, carrying the addressed word of the row returned by the bank.
- R4: A request to the held row is answered in the cycle after acceptance. Neither bank strobe is raised for it, and `req_ready` stays 1.
- R5: A write hit changes only the buffer and issues no bank write. A later read of that word returns the new value, while the bank row still holds its old contents.
- R6: A conflict while the buffer is modified first raises `bank_wr` with the held row index and the full buffer contents. It raises `bank_rd` for the new row in the next cycle, and the response follows four cycles after acceptance.
- R7: A conflict while the buffer is unmodified skips the write-back. Only `bank_rd` is raised, and the response follows three cycles after acceptance.
- R8: A write that misses or conflicts loads the row from the bank and merges the write word into it. The other words keep their bank values and the row is marked modified.
- R9: While a miss or conflict sequence runs, `req_ready` is 0. It returns to 1 in the cycle the response is given.
- R10: Every request yields exactly one one-cycle `rsp_valid` pulse. For reads, `rsp_rdata` is the stored word. For writes, it is the word as written.
- R11: `bank_rd` and `bank_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ROW_AW+log2(ROW_WORDS) | Word address: row in the upper bits, column in the lower bits |
| req_wdata | input | WORD_W | Write word |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | WORD_W | Read word, or the written word for writes |
| bank_rd | output | 1 | Open the row at `bank_row`; data arrives next cycle |
| bank_wr | output | 1 | Store `bank_wdata` into the row at `bank_row` |
| bank_row | output | ROW_AW | Row index for either strobe |
| bank_wdata | output | WORD_W*ROW_WORDS | Row written back to the bank |
| bank_rdata | input | WORD_W*ROW_WORDS | Row returned by the bank |

## Verification
Several properties are checked on every clock cycle by the assertions:
- the two bank strobes never overlap;
- a write-back is always followed by an open, and happens only while the buffer is modified;
- an open always leads to a response two cycles later;
- a hit is answered in the next cycle;
- ready is low whenever the bank is being driven.

Other behaviour only the bench scenarios can show: that the right words come back, that edits held in the buffer reach the bank only at the next conflict, that a write merge keeps the neighbouring words of the row, and that a clean buffer skips its write-back.

// File: rtl/rowbuf_pkg.sv
// Shared types for the open-row buffer controller.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package rowbuf_pkg;

    // Sequencer steps
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_OPEN  = 2'd2,
        ST_FILL  = 2'd3
    } rb_state_t;

    // Outcome of comparing a request with the held row
    typedef enum logic [1:0] {
        CLS_HIT      = 2'd0,
        CLS_MISS     = 2'd1,
        CLS_CONFLICT = 2'd2
    } rb_class_t;

endpackage

// File: rtl/rowbuf_tag.sv
// Held-row bookkeeping: valid flag, row tag and modified flag.
// Classifies a lookup row as hit, miss or conflict combinationally.
// Assumes fill and hit_write are never asserted in the same cycle.
module rowbuf_tag
    import rowbuf_pkg::*;
#(
    parameter int ROW_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ROW_AW-1:0] lookup_row,
    input  logic              fill_en,
    input  logic [ROW_AW-1:0] fill_row,
    input  logic              fill_dirty,
    input  logic              hit_write,
    output rb_class_t         cls,
    output logic [ROW_AW-1:0] open_row,
    output logic              dirty
);

    logic              valid_q;
    logic [ROW_AW-1:0] tag_q;
    logic              dirty_q;

    // Track which row is held and whether it has been modified
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            dirty_q <= 1'b0;
        end else if (fill_en) begin
            valid_q <= 1'b1;
            tag_q   <= fill_row;
            dirty_q <= fill_dirty;
        end else if (hit_write) begin
            dirty_q <= 1'b1;
        end
    end

    // Compare the lookup row against the held tag
    always_comb begin
        if (!valid_q)                 cls = CLS_MISS;
        else if (tag_q == lookup_row) cls = CLS_HIT;
        else                          cls = CLS_CONFLICT;
    end

    assign open_row = tag_q;
    assign dirty    = dirty_q;

    AST_DIRTY_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_q |-> valid_q);                                   // R8

endmodule

// File: rtl/rowbuf_data.sv
// Full-row buffer register, one word register per column.
// A word write takes precedence over a row fill for its own column, so a
// fill and a write in the same cycle merge the write word into the new row.
module rowbuf_data #(
    parameter int WORD_W    = 8,
    parameter int ROW_WORDS = 4,
    parameter int COL_AW    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fill_en,
    input  logic [WORD_W*ROW_WORDS-1:0] fill_data,
    input  logic                        wr_en,
    input  logic [COL_AW-1:0]           col,
    input  logic [WORD_W-1:0]           wdata,
    output logic [WORD_W*ROW_WORDS-1:0] row_out,
    output logic [WORD_W-1:0]           word_out
);

    logic [WORD_W-1:0] word_q [ROW_WORDS];

    for (genvar g = 0; g < ROW_WORDS; g++) begin : g_word
        // Load one column from a fill or from a word write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else if (wr_en && (col == COL_AW'(g))) begin
                word_q[g] <= wdata;
            end else if (fill_en) begin
                word_q[g] <= fill_data[g*WORD_W +: WORD_W];
            end
        end
        assign row_out[g*WORD_W +: WORD_W] = word_q[g];
    end

    // Select the addressed column
    always_comb begin
        word_out = word_q[0];
        for (int i = 0; i < ROW_WORDS; i++) begin
            if (col == COL_AW'(i)) word_out = word_q[i];
        end
    end

endmodule

// File: rtl/rowbuf_fsm.sv
// Request sequencer: accepts one request at a time in idle, answers hits at
// once, and walks write-back, open and fill steps for misses and conflicts.
// Assumes the bank returns a row one cycle after its read strobe.
module rowbuf_fsm
    import rowbuf_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int ROW_WORDS = 4,
    parameter int ROW_AW    = 3,
    parameter int COL_AW    = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ROW_AW-1:0]           req_row,
    input  logic [COL_AW-1:0]           req_col,
    input  logic [WORD_W-1:0]           req_wdata,
    input  rb_class_t                   cls,
    input  logic [ROW_AW-1:0]           open_row,
    input  logic                        dirty,
    input  logic [WORD_W-1:0]           buf_word,
    input  logic [WORD_W*ROW_WORDS-1:0] bank_rdata,
    output logic                        req_ready,
    output logic                        bank_rd,
    output logic                        bank_wr,
    output logic [ROW_AW-1:0]           bank_row,
    output logic                        fill_en,
    output logic [ROW_AW-1:0]           fill_row,
    output logic                        fill_dirty,
    output logic                        hit_write,
    output logic                        buf_wr_en,
    output logic [COL_AW-1:0]           buf_col,
    output logic [WORD_W-1:0]           buf_wdata,
    output logic                        rsp_valid,
    output logic [WORD_W-1:0]           rsp_rdata
);

    rb_state_t         state_q, state_d;
    logic              p_write_q;
    logic [ROW_AW-1:0] p_row_q;
    logic [COL_AW-1:0] p_col_q;
    logic [WORD_W-1:0] p_wdata_q;
    logic              rsp_valid_q;
    logic [WORD_W-1:0] rsp_rdata_q;
    logic              accept;
    logic              hit_now;
    logic [WORD_W-1:0] bank_word;

    assign accept    = req_valid && (state_q == ST_IDLE);
    assign hit_now   = accept && (cls == CLS_HIT);
    assign bank_word = bank_rdata[p_col_q*WORD_W +: WORD_W];

    // Next-step selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && cls != CLS_HIT) begin
                    state_d = (cls == CLS_CONFLICT && dirty) ? ST_WBACK : ST_OPEN;
                end
            end
            ST_WBACK: state_d = ST_OPEN;
            ST_OPEN:  state_d = ST_FILL;
            ST_FILL:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Step register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the request that starts a multi-cycle sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_write_q <= 1'b0;
            p_row_q   <= '0;
            p_col_q   <= '0;
            p_wdata_q <= '0;
        end else if (accept && cls != CLS_HIT) begin
            p_write_q <= req_write;
            p_row_q   <= req_row;
            p_col_q   <= req_col;
            p_wdata_q <= req_wdata;
        end
    end

    // Bank strobes and row index per step
    always_comb begin
        bank_rd  = (state_q == ST_OPEN);
        bank_wr  = (state_q == ST_WBACK);
        bank_row = (state_q == ST_WBACK) ? open_row : p_row_q;
    end

    // Buffer and tag controls: hit edits in idle, merged fill in the last step
    always_comb begin
        fill_en    = (state_q == ST_FILL);
        fill_row   = p_row_q;
        fill_dirty = p_write_q;
        hit_write  = hit_now && req_write;
        if (state_q == ST_IDLE) begin
            buf_wr_en = hit_now && req_write;
            buf_col   = req_col;
            buf_wdata = req_wdata;
        end else begin
            buf_wr_en = (state_q == ST_FILL) && p_write_q;
            buf_col   = p_col_q;
            buf_wdata = p_wdata_q;
        end
    end

    // Registered completion pulse and word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= hit_now || (state_q == ST_FILL);
            if (hit_now) begin
                rsp_rdata_q <= req_write ? req_wdata : buf_word;
            end else if (state_q == ST_FILL) begin
                rsp_rdata_q <= p_write_q ? p_wdata_q : bank_word;
            end
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bank_rd && bank_wr));                                 // R11
    AST_WBACK_THEN_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |=> bank_rd);                                   // R6
    AST_WBACK_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |-> dirty);                                     // R7
    AST_OPEN_TO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        bank_rd |=> ##1 rsp_valid);                             // R3
    AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_rd || bank_wr) |-> !req_ready);                   // R9
    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && cls == CLS_HIT) |=> (rsp_valid && !bank_rd && !bank_wr)); // R4

endmodule

// File: rtl/rowbuf_ctrl.sv
// Open-row buffer controller top: splits the word address into row and
// column, and joins the tag tracker, row buffer and sequencer.
// Assumes a bank with one-cycle row reads and edge-captured row writes.
module rowbuf_ctrl
    import rowbuf_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int ROW_WORDS = 4,
    parameter int ROW_AW    = 3,
    localparam int COL_AW   = $clog2(ROW_WORDS),
    localparam int ADDR_W   = ROW_AW + COL_AW,
    localparam int ROW_W    = WORD_W * ROW_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              bank_rd,
    output logic              bank_wr,
    output logic [ROW_AW-1:0] bank_row,
    output logic [ROW_W-1:0]  bank_wdata,
    input  logic [ROW_W-1:0]  bank_rdata
);

    logic [ROW_AW-1:0] req_row;
    logic [COL_AW-1:0] req_col;
    rb_class_t         cls;
    logic [ROW_AW-1:0] open_row;
    logic              dirty;
    logic              fill_en;
    logic [ROW_AW-1:0] fill_row;
    logic              fill_dirty;
    logic              hit_write;
    logic              buf_wr_en;
    logic [COL_AW-1:0] buf_col;
    logic [WORD_W-1:0] buf_wdata;
    logic [WORD_W-1:0] buf_word;

    assign req_row = req_addr[ADDR_W-1:COL_AW];
    assign req_col = req_addr[COL_AW-1:0];

    rowbuf_tag #(.ROW_AW(ROW_AW)) u_tag (
        .clk        (clk),
        .rst_n      (rst_n),
        .lookup_row (req_row),
        .fill_en    (fill_en),
        .fill_row   (fill_row),
        .fill_dirty (fill_dirty),
        .hit_write  (hit_write),
        .cls        (cls),
        .open_row   (open_row),
        .dirty      (dirty)
    );

    rowbuf_data #(.WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS), .COL_AW(COL_AW)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .fill_en   (fill_en),
        .fill_data (bank_rdata),
        .wr_en     (buf_wr_en),
        .col       (buf_col),
        .wdata     (buf_wdata),
        .row_out   (bank_wdata),
        .word_out  (buf_word)
    );

    rowbuf_fsm #(.WORD_W(WORD_W), .ROW_WORDS(ROW_WORDS), .ROW_AW(ROW_AW), .COL_AW(COL_AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_row    (req_row),
        .req_col    (req_col),
        .req_wdata  (req_wdata),
        .cls        (cls),
        .open_row   (open_row),
        .dirty      (dirty),
        .buf_word   (buf_word),
        .bank_rdata (bank_rdata),
        .req_ready  (req_ready),
        .bank_rd    (bank_rd),
        .bank_wr    (bank_wr),
        .bank_row   (bank_row),
        .fill_en    (fill_en),
        .fill_row   (fill_row),
        .fill_dirty (fill_dirty),
        .hit_write  (hit_write),
        .buf_wr_en  (buf_wr_en),
        .buf_col    (buf_col),
        .buf_wdata  (buf_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    AST_FILL_AFTER_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |-> !req_ready);                                // R8

endmodule

// File: tb/rowbuf_ctrl_test.sv
// Self-checking bench: a behavioural bank, a word-level reference memory
// and a held-row model predict every output on every cycle of a request.
module rowbuf_ctrl_test;

    localparam int WW = 8;
    localparam int RW = 4;
    localparam int RA = 3;
    localparam int CA = 2;
    localparam int AW = RA + CA;
    localparam int NR = 1 << RA;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [WW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [WW-1:0] rsp_rdata;
    logic          bank_rd, bank_wr;
    logic [RA-1:0] bank_row;
    logic [WW*RW-1:0] bank_wdata;
    logic [WW*RW-1:0] bank_rdata;

    logic [WW*RW-1:0] bank_mem [NR];
    logic [WW-1:0]    ref_mem [NR*RW];
    bit               m_open = 0;
    int               m_tag = 0;
    bit               m_dirty = 0;
    int               n_total = 0;
    int               n_fail = 0;

    always #4 clk = ~clk;

    rowbuf_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .bank_rd(bank_rd),
        .bank_wr(bank_wr), .bank_row(bank_row), .bank_wdata(bank_wdata),
        .bank_rdata(bank_rdata)
    );

    function automatic logic [WW-1:0] init_word(int r, int c);
        return WW'((r * 16 + c) ^ 8'hA5);
    endfunction

    // Bank model: one-cycle row read, edge-captured row write
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NR; r++)
                for (int c = 0; c < RW; c++)
                    bank_mem[r][c*WW +: WW] <= init_word(r, c);
            bank_rdata <= '0;
        end else begin
            if (bank_wr) bank_mem[bank_row] <= bank_wdata;
            if (bank_rd) bank_rdata <= bank_mem[bank_row];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [WW*RW-1:0] ref_row(int r);
        logic [WW*RW-1:0] v;
        for (int c = 0; c < RW; c++) v[c*WW +: WW] = ref_mem[r*RW + c];
        return v;
    endfunction

    // Issue one request and compare every cycle until its response
    task automatic do_req(input bit wr, input int row, input int col, input logic [WW-1:0] wd,
                          input string tag);
        bit hit, wb;
        int lat;
        logic [WW-1:0] exp_data;
        logic [WW*RW-1:0] exp_wb;
        int old_tag;
        hit = m_open && (m_tag == row);
        wb = m_open && !hit && m_dirty;
        lat = hit ? 1 : (wb ? 4 : 3);
        old_tag = m_tag;
        exp_wb = ref_row(m_tag);
        @(negedge clk);
        chk(req_ready === 1'b1, {tag, " R9 ready before accept"}, 64'(req_ready), 1);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = AW'((row << CA) | col);
        req_wdata = wd;
        if (wr) ref_mem[row*RW + col] = wd;
        exp_data = ref_mem[row*RW + col];
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 1; cyc <= lat; cyc++) begin
            chk(rsp_valid === (cyc == lat), {tag, " R10 rsp_valid timing"}, 64'(rsp_valid), 64'(cyc == lat));
            chk(req_ready === (cyc == lat), {tag, " R9 ready timing"}, 64'(req_ready), 64'(cyc == lat));
            chk(bank_wr === (wb && cyc == 1), {tag, " R6/R7 write-back strobe"}, 64'(bank_wr), 64'(wb && cyc == 1));
            chk(bank_rd === (!hit && cyc == lat - 2), {tag, " R3/R4 open strobe"}, 64'(bank_rd), 64'(!hit && cyc == lat - 2));
            chk(!(bank_rd && bank_wr), {tag, " R11 strobes exclusive"}, 64'({bank_rd, bank_wr}), 0);
            if (bank_wr) begin
                chk(bank_row === RA'(old_tag), {tag, " R6 write-back row"}, 64'(bank_row), 64'(old_tag));
                chk(bank_wdata === exp_wb, {tag, " R6 write-back data"}, 64'(bank_wdata), 64'(exp_wb));
            end
            if (bank_rd)
                chk(bank_row === RA'(row), {tag, " R2/R3 open row"}, 64'(bank_row), 64'(row));
            if (cyc == lat)
                chk(rsp_rdata === exp_data, {tag, " R10 response word"}, 64'(rsp_rdata), 64'(exp_data));
            if (cyc < lat) @(negedge clk);
        end
        if (hit) begin
            if (wr) m_dirty = 1;
        end else begin
            m_open = 1;
            m_tag = row;
            m_dirty = wr;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < RW; c++) ref_mem[r*RW + c] = init_word(r, c);
        chk(req_ready === 1'b1, "R1 ready after reset", 64'(req_ready), 1);
        chk(rsp_valid === 1'b0, "R1 no response after reset", 64'(rsp_valid), 0);
        chk(!bank_rd && !bank_wr, "R1 strobes low after reset", 64'({bank_rd, bank_wr}), 0);

        do_req(0, 0, 0, 0, "R1 R3 first read miss");
        do_req(0, 0, 2, 0, "R4 read hit");
        do_req(1, 0, 1, 8'h3C, "R5 write hit");
        chk(bank_mem[0][1*WW +: WW] === init_word(0, 1), "R5 bank untouched by write hit",
            64'(bank_mem[0][1*WW +: WW]), 64'(init_word(0, 1)));
        do_req(0, 0, 1, 0, "R5 read back edit");
        do_req(0, 2, 3, 0, "R6 dirty conflict");
        chk(bank_mem[0][1*WW +: WW] === 8'h3C, "R6 edit reached bank",
            64'(bank_mem[0][1*WW +: WW]), 64'h3C);
        do_req(0, 2, 0, 0, "R4 hit after conflict");
        do_req(0, 5, 1, 0, "R7 clean conflict");
        do_req(1, 6, 2, 8'h77, "R8 write conflict merge");
        do_req(0, 6, 2, 0, "R8 merged word");
        do_req(0, 6, 0, 0, "R8 neighbour kept");
        do_req(0, 1, 3, 0, "R6 second dirty conflict");
        chk(bank_mem[6] === ref_row(6), "R8 merged row in bank", 64'(bank_mem[6]), 64'(ref_row(6)));
        do_req(1, 1, 0, 8'hE1, "R5 write hit second");
        do_req(1, 1, 3, 8'h5A, "R5 write hit third");
        do_req(0, 1, 0, 0, "R2 column select");
        do_req(0, 7, 3, 0, "R6 top row conflict");
        chk(bank_mem[1] === ref_row(1), "R6 row one written back", 64'(bank_mem[1]), 64'(ref_row(1)));

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_total++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule